// File: doc/BRIEF.md
# Lockstep Instruction Broadcast Controller

This controller sits between the fetch stages of a 16-core cluster, their private instruction caches and their decode stages. In independent mode it passes every core's fetch requests, cache responses and decode handshakes straight through, so each core runs its own instruction stream. In lockstep mode core 0 leads. Only the leader reaches its cache. Each instruction the leader receives goes to all sixteen decoders in the same cycle. The fetch stages and private caches of cores 1 to 15 are clock-gated.

Software writes the requested mode through a one-bit register port. The switch waits until every core reports idle at a barrier. When the cluster leaves lockstep, it passes through one wake cycle. In that cycle the follower clock enables are already high, follower fetch is still held off, and the followers' program counters are loaded with the leader's next program counter. A status output shows the current mode, and a counter records how many cycles the followers spent gated.

Top module: `lockstep_fetch_ctrl`

## Requirements
- R1: After reset the block is in independent mode (status_lockstep = 0). All fetch_ce and cache_ce bits are 1, pc_load_valid is 0 and gated_cycles is 0.
- R2: In independent mode every core i gets a straight path. ic_req_valid[i] = core_req_valid[i], ic_req_addr slice i = core_req_addr slice i, core_req_ready[i] = ic_req_ready[i], dec_valid[i] = ic_rsp_valid[i], dec_instr slice i = ic_rsp_data slice i, and ic_rsp_ready[i] = dec_ready[i].
- R3: In lockstep mode, ic_req_valid and core_req_ready are 0 for cores 1 to 15. Core 0's request path behaves as in R2.
- R4: In lockstep mode all sixteen dec_instr slices carry ic_rsp_data slice 0. Every dec_valid bit equals ic_rsp_valid[0] AND all sixteen dec_ready bits.
- R5: In lockstep mode ic_rsp_ready[0] is 1 only when all sixteen dec_ready bits are 1, so one stalled core stalls the leader.
- R6: In lockstep mode ic_rsp_ready is 1 for cores 1 to 15, so their responses are drained. Those responses never reach a decoder.
- R7: mode_wr captures mode_wdata as the requested mode (1 = lockstep, 0 = independent). The mode changes only on an edge where the requested mode differs from the current one and all core_idle bits are 1. Writing the current mode has no effect.
- R8: fetch_ce and cache_ce are registered. For cores 1 to 15 they are 0 in exactly the cycles when status_lockstep is 1. They fall on the same edge that enters lockstep. Bit 0 of each stays at 1.
- R9: Leaving lockstep passes through exactly one wake cycle. In that cycle status_lockstep = 0, all clock enables = 1, pc_load_valid = 1, pc_load_addr holds the value leader_next_pc had at the switching edge, and follower ic_req_valid is 0. Independent operation (R2) starts on the next cycle.
- R10: gated_cycles increases by one on every clock edge at which the block is in lockstep mode, and saturates at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_wr | input | 1 | Write strobe for the mode request |
| mode_wdata | input | 1 | Requested mode, 1 = lockstep |
| core_idle | input | 16 | Per-core barrier idle flags |
| leader_next_pc | input | 32 | Leader's next program counter |
| core_req_valid | input | 16 | Fetch request valid from each core |
| core_req_addr | input | 512 | Fetch addresses, 32 bits per core |
| core_req_ready | output | 16 | Fetch request ready back to each core |
| ic_req_valid | output | 16 | Request valid to each instruction cache |
| ic_req_addr | output | 512 | Request addresses to the caches |
| ic_req_ready | input | 16 | Cache request ready |
| ic_rsp_valid | input | 16 | Cache response valid |
| ic_rsp_data | input | 512 | Cache response instructions |
| ic_rsp_ready | output | 16 | Response ready to each cache |
| dec_valid | output | 16 | Instruction valid to each decoder |
| dec_instr | output | 512 | Instruction to each decoder |
| dec_ready | input | 16 | Decoder ready |
| fetch_ce | output | 16 | Registered fetch-stage clock enables |
| cache_ce | output | 16 | Registered private-cache clock enables |
| pc_load_valid | output | 1 | Follower program-counter load strobe |
| pc_load_addr | output | 32 | Value to load into the follower program counters |
| status_lockstep | output | 1 | Current mode, 1 = lockstep |
| gated_cycles | output | 32 | Count of cycles with followers gated |

## Verification
The assertions assume that core_idle is raised only when a core has no instruction in flight. They also assume that dec_ready never depends on dec_valid in the same cycle, which keeps the all-ready broadcast free of combinational loops. The bench meets both assumptions. It drives ready, valid and idle as independent stored patterns, and it raises all idle flags only around mode writes. No fetch traffic is pending across a switch, except for the deliberate follower requests used to check that the wake cycle holds follower fetch off.

// File: rtl/lockstep_fetch_ctrl.sv
module lockstep_fetch_ctrl #(
  parameter int NCORES = 16,
  parameter int AW     = 32,
  parameter int IW     = 32,
  parameter int CNTW   = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_wr,
  input  logic                 mode_wdata,
  input  logic [NCORES-1:0]    core_idle,
  input  logic [AW-1:0]        leader_next_pc,
  input  logic [NCORES-1:0]    core_req_valid,
  input  logic [NCORES*AW-1:0] core_req_addr,
  output logic [NCORES-1:0]    core_req_ready,
  output logic [NCORES-1:0]    ic_req_valid,
  output logic [NCORES*AW-1:0] ic_req_addr,
  input  logic [NCORES-1:0]    ic_req_ready,
  input  logic [NCORES-1:0]    ic_rsp_valid,
  input  logic [NCORES*IW-1:0] ic_rsp_data,
  output logic [NCORES-1:0]    ic_rsp_ready,
  output logic [NCORES-1:0]    dec_valid,
  output logic [NCORES*IW-1:0] dec_instr,
  input  logic [NCORES-1:0]    dec_ready,
  output logic [NCORES-1:0]    fetch_ce,
  output logic [NCORES-1:0]    cache_ce,
  output logic                 pc_load_valid,
  output logic [AW-1:0]        pc_load_addr,
  output logic                 status_lockstep,
  output logic [CNTW-1:0]      gated_cycles
);

  localparam logic [1:0] ST_IND  = 2'd0;
  localparam logic [1:0] ST_LOCK = 2'd1;
  localparam logic [1:0] ST_WAKE = 2'd2;

  logic [1:0] st, st_nx;
  logic       want_lock;

  wire lock      = (st == ST_LOCK);
  wire wake      = (st == ST_WAKE);
  wire all_idle  = &core_idle;
  wire all_ready = &dec_ready;
  wire bcast_go  = ic_rsp_valid[0] & all_ready;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IND:  if (want_lock && all_idle)  st_nx = ST_LOCK;
      ST_LOCK: if (!want_lock && all_idle) st_nx = ST_WAKE;
      default: st_nx = ST_IND;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= ST_IND;
      want_lock     <= 1'b0;
      fetch_ce      <= '1;
      cache_ce      <= '1;
      pc_load_valid <= 1'b0;
      pc_load_addr  <= '0;
      gated_cycles  <= '0;
    end else begin
      if (mode_wr) want_lock <= mode_wdata;
      st            <= st_nx;
      fetch_ce      <= {{(NCORES-1){st_nx != ST_LOCK}}, 1'b1};
      cache_ce      <= {{(NCORES-1){st_nx != ST_LOCK}}, 1'b1};
      pc_load_valid <= (st_nx == ST_WAKE);
      if (st_nx == ST_WAKE && !wake) pc_load_addr <= leader_next_pc;
      if (lock && !(&gated_cycles)) gated_cycles <= gated_cycles + 1'b1;
    end
  end

  assign status_lockstep = lock;
  assign ic_req_addr     = core_req_addr;

  for (genvar i = 0; i < NCORES; i++) begin : g_core
    if (i == 0) begin : g_lead
      assign ic_req_valid[0]   = core_req_valid[0];
      assign core_req_ready[0] = ic_req_ready[0];
      assign ic_rsp_ready[0]   = lock ? all_ready : dec_ready[0];
      assign dec_valid[0]      = lock ? bcast_go : ic_rsp_valid[0];
      assign dec_instr[IW-1:0] = ic_rsp_data[IW-1:0];
    end else begin : g_follow
      wire open = !lock && !wake;
      assign ic_req_valid[i]   = core_req_valid[i] & open;
      assign core_req_ready[i] = ic_req_ready[i] & open;
      assign ic_rsp_ready[i]   = open ? dec_ready[i] : 1'b1;
      assign dec_valid[i]      = lock ? bcast_go : (ic_rsp_valid[i] & open);
      assign dec_instr[i*IW +: IW] = lock ? ic_rsp_data[IW-1:0] : ic_rsp_data[i*IW +: IW];
    end
  end

  assert_follower_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    status_lockstep |-> (ic_req_valid[NCORES-1:1] == '0 && core_req_ready[NCORES-1:1] == '0));

  assert_bcast_same_R4: assert property (@(posedge clk) disable iff (!rst_n)
    status_lockstep |-> (dec_valid == '0 || dec_valid == '1));

  assert_leader_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_lockstep && !ic_rsp_ready[0]) |-> (dec_valid == '0));

  assert_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    status_lockstep |-> (ic_rsp_ready[NCORES-1:1] == '1));

  assert_switch_at_barrier_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_lockstep != $past(status_lockstep)) |-> $past(&core_idle));

  assert_gated_ce_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status_lockstep |-> (fetch_ce[NCORES-1:1] == '0 && cache_ce[NCORES-1:1] == '0 && fetch_ce[0] && cache_ce[0]));

  assert_wake_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_valid |=> (!pc_load_valid && !status_lockstep));

  assert_wake_ce_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_valid |-> (fetch_ce == '1 && cache_ce == '1 && ic_req_valid[NCORES-1:1] == '0));

  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(status_lockstep) && !(&$past(gated_cycles))) |-> (gated_cycles == $past(gated_cycles) + 1'b1));

endmodule

// File: tb/sim_lockstep_fetch_ctrl.sv
module sim_lockstep_fetch_ctrl;
  localparam int N = 16;
  localparam int AW = 32;
  localparam int IW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_wr = 1'b0, mode_wdata = 1'b0;
  logic [N-1:0] core_idle = '0;
  logic [AW-1:0] leader_next_pc = '0;
  logic [N-1:0] core_req_valid = '0, ic_req_ready = '0, ic_rsp_valid = '0, dec_ready = '0;
  logic [N*AW-1:0] core_req_addr = '0;
  logic [N*IW-1:0] ic_rsp_data = '0;
  logic [N-1:0] core_req_ready, ic_req_valid, ic_rsp_ready, dec_valid, fetch_ce, cache_ce;
  logic [N*AW-1:0] ic_req_addr;
  logic [N*IW-1:0] dec_instr;
  logic pc_load_valid, status_lockstep;
  logic [AW-1:0] pc_load_addr;
  logic [31:0] gated_cycles;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lockstep_fetch_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .core_idle(core_idle), .leader_next_pc(leader_next_pc),
    .core_req_valid(core_req_valid), .core_req_addr(core_req_addr), .core_req_ready(core_req_ready),
    .ic_req_valid(ic_req_valid), .ic_req_addr(ic_req_addr), .ic_req_ready(ic_req_ready),
    .ic_rsp_valid(ic_rsp_valid), .ic_rsp_data(ic_rsp_data), .ic_rsp_ready(ic_rsp_ready),
    .dec_valid(dec_valid), .dec_instr(dec_instr), .dec_ready(dec_ready),
    .fetch_ce(fetch_ce), .cache_ce(cache_ce),
    .pc_load_valid(pc_load_valid), .pc_load_addr(pc_load_addr),
    .status_lockstep(status_lockstep), .gated_cycles(gated_cycles));

  // {lock, rsp_valid, dec_ready, req_valid, ic_req_ready}
  localparam logic [64:0] VEC [10] = '{
    {1'b0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF},
    {1'b0, 16'hA5A5, 16'h0F0F, 16'h3C3C, 16'h5555},
    {1'b0, 16'h0001, 16'hFFFE, 16'h8000, 16'h00FF},
    {1'b0, 16'h1234, 16'hFEDC, 16'h0F0F, 16'hAAAA},
    {1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h0000},
    {1'b1, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF},
    {1'b1, 16'h0001, 16'hFFFF, 16'hFFFE, 16'h0001},
    {1'b1, 16'hFFFE, 16'hFFFF, 16'h0001, 16'hFFFE},
    {1'b1, 16'h0001, 16'hFF7F, 16'hFFFF, 16'hFFFF},
    {1'b1, 16'hFFFF, 16'h7FFF, 16'h0001, 16'h0000}
  };

  task automatic chk(input string tag, input logic [N*IW-1:0] act, input logic [N*IW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic set_mode(input logic m);
    core_idle = '1;
    mode_wr = 1'b1; mode_wdata = m;
    tick();
    mode_wr = 1'b0;
    tick();
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic cur_lock;
    logic [N*IW-1:0] exp_instr;
    logic [N*IW-1:0] own_instr;
    logic [31:0] c0;
    for (int i = 0; i < N; i++)
      core_req_addr[i*AW +: AW] = 32'h0001_0000 * i + 32'h40;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 status", {511'b0, status_lockstep}, '0);
    chk("R1 ce", {480'b0, fetch_ce, cache_ce}, {480'b0, 32'hFFFF_FFFF});
    chk("R1 pc_load/count", {479'b0, pc_load_valid, gated_cycles}, '0);

    // R7 writing the current mode has no effect
    core_idle = '1;
    mode_wr = 1'b1; mode_wdata = 1'b0; tick(); mode_wr = 1'b0;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R7 same-mode write", {510'b0, status_lockstep, pc_load_valid}, '0);
    end

    // table walk
    cur_lock = 1'b0;
    for (int v = 0; v < 10; v++) begin
      logic lk;
      logic [15:0] rv, dr, qv, ir;
      {lk, rv, dr, qv, ir} = VEC[v];
      if (lk != cur_lock) begin set_mode(lk); cur_lock = lk; end
      for (int i = 0; i < N; i++)
        ic_rsp_data[i*IW +: IW] = 32'hD000_0000 | (i << 12) | v;
      ic_rsp_valid = rv; dec_ready = dr; core_req_valid = qv; ic_req_ready = ir;
      #1;
      own_instr = ic_rsp_data;
      for (int i = 0; i < N; i++) exp_instr[i*IW +: IW] = ic_rsp_data[IW-1:0];
      if (!lk) begin
        chk("R2 dec_valid", {496'b0, dec_valid}, {496'b0, rv});
        chk("R2 dec_instr", dec_instr, own_instr);
        chk("R2 ic_req_valid", {496'b0, ic_req_valid}, {496'b0, qv});
        chk("R2 ic_req_addr", ic_req_addr, core_req_addr);
        chk("R2 core_req_ready", {496'b0, core_req_ready}, {496'b0, ir});
        chk("R2 ic_rsp_ready", {496'b0, ic_rsp_ready}, {496'b0, dr});
      end else begin
        chk("R4 dec_valid", {496'b0, dec_valid}, {496'b0, {16{rv[0] & (&dr)}}});
        chk("R4 dec_instr", dec_instr, exp_instr);
        chk("R3 ic_req_valid", {496'b0, ic_req_valid}, {496'b0, 15'b0, qv[0]});
        chk("R3 core_req_ready", {496'b0, core_req_ready}, {496'b0, 15'b0, ir[0]});
        chk("R5 leader rsp_ready", {511'b0, ic_rsp_ready[0]}, {511'b0, &dr});
        chk("R6 follower rsp_ready", {497'b0, ic_rsp_ready[N-1:1]}, {497'b0, 15'h7FFF});
      end
    end
    ic_rsp_valid = '0; core_req_valid = '0; dec_ready = '1;

    // R10 gated count in lockstep
    c0 = gated_cycles;
    repeat (10) tick();
    chk("R10 gated count", {480'b0, gated_cycles}, {480'b0, c0 + 32'd10});
    chk("R8 ce in lockstep", {480'b0, fetch_ce, cache_ce}, {480'b0, 32'h0001_0001});

    // R9 exit through one wake cycle
    leader_next_pc = 32'h8000_0040;
    core_req_valid = '1;
    core_idle = '1;
    mode_wr = 1'b1; mode_wdata = 1'b0; tick(); mode_wr = 1'b0;
    leader_next_pc = 32'h8000_0000;
    tick();
    leader_next_pc = 32'h1234_5678;
    #1;
    chk("R9 wake status", {510'b0, status_lockstep, pc_load_valid}, {510'b0, 2'b01});
    chk("R9 wake ce", {480'b0, fetch_ce, cache_ce}, {480'b0, 32'hFFFF_FFFF});
    chk("R9 wake pc", {480'b0, pc_load_addr}, {480'b0, 32'h8000_0000});
    chk("R9 wake fetch held", {496'b0, ic_req_valid}, {496'b0, 16'h0001});
    tick();
    chk("R9 after wake", {511'b0, pc_load_valid}, '0);
    chk("R9 independent fetch", {496'b0, ic_req_valid}, {496'b0, 16'hFFFF});
    core_req_valid = '0;

    // R7 barrier gating, R8 ce timing on entry
    core_idle = 16'h7FFF;
    mode_wr = 1'b1; mode_wdata = 1'b1; tick(); mode_wr = 1'b0;
    for (int k = 0; k < 4; k++) begin
      tick();
      chk("R7 waits for barrier", {511'b0, status_lockstep}, '0);
    end
    chk("R8 ce before entry", {480'b0, fetch_ce, cache_ce}, {480'b0, 32'hFFFF_FFFF});
    core_idle = '1;
    tick();
    chk("R7 switch at barrier", {511'b0, status_lockstep}, {511'b0, 1'b1});
    chk("R8 ce on entry edge", {480'b0, fetch_ce, cache_ce}, {480'b0, 32'h0001_0001});

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule